// File: doc/BRIEF.md
# Byte-Packing Data Port FIFO

This block sits between a 16-bit host data register and a byte-serial transfer engine. It holds up to four bytes in one shared buffer and keeps two separate counts, one for bytes waiting to be sent and one for bytes received. Host writes of a half-word or a single byte queue bytes for transmission. Host half-word reads hand back the two oldest received bytes. A byte-order input selects which byte of each half-word counts as the earlier one on the bus.

The engine side is a plain strobe interface. The engine takes the oldest queued transmit byte with a pop strobe and delivers a received byte with a push strobe. The block keeps the data-path status flags: transmit-ready, receive-ready, single-byte-data, transmit-underflow and receive-overrun. After every host access the block raises a one-cycle kick, so that the engine can resume moving bytes. When a read drains the receive side of a master receive transfer, the block signals that access-ready is to be set and master mode is to be left. Bus signalling belongs to the engine and is not part of this block.

Only one direction is active at a time. Transmit bytes and receive bytes share the same storage.

Top module: `bytepack_data_port`

## Requirements
- R1: A half-word write (host_wr16) is accepted only when at most 2 transmit bytes are queued. It adds 2 bytes to the transmit queue. When 3 or 4 bytes are already queued, the write has no effect: the transmit queue, its byte order and the status flags stay as they were.
- R2: The engine always sees the oldest queued transmit byte on eng_tx_byte, and eng_tx_pop removes it. For an accepted half-word write with swap_order=1, host_wdata[15:8] is sent before host_wdata[7:0]. With swap_order=0, host_wdata[7:0] is sent first.
- R3: A byte write (host_wr8) appends host_wdata[7:0] as one byte after the bytes already queued. It is accepted under the same limit as R1 (at most 2 bytes queued), so after a byte write that leaves 3 bytes queued, a further byte write is rejected.
- R4: An accepted write clears transmit-underflow (status bit 10). If more than 2 transmit bytes are queued after the write, it also clears transmit-ready (status bit 4). eng_xrdy_set sets bit 4 and eng_xudf_set sets bit 10.
- R5: During a host_rd cycle, host_rdata carries the two oldest received bytes. With swap_order=0 the oldest byte is in [7:0]. With swap_order=1 the oldest byte is in [15:8]. When only one byte is held, that byte is in the same half, [7:0] or [15:8], that carries the oldest byte.
- R6: A read with exactly one byte held sets single-byte-data (status bit 15) and empties the receive side. A read with 2 or more bytes held removes 2 bytes, and the remaining bytes move down to become the oldest.
- R7: An engine push that is accepted sets receive-ready (status bit 3). A read that leaves no received byte clears bit 3. If that read happens with master_on=1 and xmit_dir=0, rx_finish pulses high for one cycle after it.
- R8: Every read clears receive-overrun (status bit 11). An engine push while 4 bytes are already held is dropped and sets bit 11.
- R9: kick is high for exactly the one cycle after each host access cycle (host_wr16, host_wr8 or host_rd), whether or not the access was accepted.
- R10: In a cycle where any host strobe is high, engine pop, push, eng_xrdy_set and eng_xudf_set are ignored, and eng_tx_avail and eng_rx_space are low. Otherwise:
  - eng_tx_avail is high when at least one transmit byte is queued.
  - eng_rx_space is high when fewer than 4 bytes are held.
  - A pop with nothing queued is ignored.
  - A 1 on flag_clr clears the matching status bit, but a set event in the same cycle takes precedence.
  - All status bits are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr16 | input | 1 | Half-word write strobe |
| host_wr8 | input | 1 | Byte write strobe (last byte only) |
| host_rd | input | 1 | Half-word read strobe |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, valid during the host_rd cycle |
| swap_order | input | 1 | Byte order: 1 means the high byte is the earlier byte |
| master_on | input | 1 | Master mode is active |
| xmit_dir | input | 1 | Transfer direction, 1 means transmit |
| flag_clr | input | 16 | Write-one-to-clear mask at the status bit positions |
| status | output | 16 | Flags: bit 3 rx ready, 4 tx ready, 10 tx underflow, 11 rx overrun, 15 single byte |
| eng_tx_avail | output | 1 | A transmit byte can be popped |
| eng_tx_byte | output | 8 | Oldest queued transmit byte |
| eng_tx_pop | input | 1 | Engine takes eng_tx_byte |
| eng_rx_space | output | 1 | A received byte can be pushed |
| eng_rx_push | input | 1 | Engine delivers eng_rx_byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_xrdy_set | input | 1 | Engine requests transmit-ready |
| eng_xudf_set | input | 1 | Engine reports transmit underflow |
| kick | output | 1 | One-cycle pulse after a host access |
| rx_finish | output | 1 | One-cycle pulse: set access-ready and leave master mode |

## Verification
Results fall into three timing classes:

- **Same cycle.** host_rdata, eng_tx_avail and eng_rx_space are combinational in the cycle of the stimulus. The bench drives each cycle's inputs on the falling edge and compares these outputs one nanosecond later, before the next rising edge.
- **Next cycle.** Queue contents and the status flags change on the rising edge that ends the access. kick and rx_finish rise on that same edge and are high for the following cycle. The bench compares all of these on the next falling edge, before it drives new inputs.
- **Queue readout.** eng_tx_byte follows the queue state, so it is checked on the falling edge after the write or pop that changed it.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int HOST_BYTES = 2;
  localparam int STAT_W     = 16;
  localparam int FLG_RRDY   = 3;
  localparam int FLG_XRDY   = 4;
  localparam int FLG_XUDF   = 10;
  localparam int FLG_ROVR   = 11;
  localparam int FLG_SBD    = 15;
endpackage

// File: rtl/hbp_lane_swap.sv
module hbp_lane_swap #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      en,
  input  logic [LANES*BYTE_W-1:0]   din,
  output logic [LANES*BYTE_W-1:0]   dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign dout[i*BYTE_W +: BYTE_W] = en ? din[(LANES-1-i)*BYTE_W +: BYTE_W]
                                         : din[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/hbp_buffer.sv
module hbp_buffer
  import hbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_word_en,
  input  logic                          wr_byte_en,
  input  logic [HOST_BYTES*BYTE_W-1:0]  wr_word,
  input  logic [BYTE_W-1:0]             wr_byte,
  input  logic                          rd_en,
  input  logic                          tx_pop,
  input  logic                          rx_push,
  input  logic [BYTE_W-1:0]             rx_byte,
  output logic [HOST_BYTES*BYTE_W-1:0]  head_word,
  output logic [BYTE_W-1:0]             tx_head,
  output logic                          tx_nonempty,
  output logic                          rx_notfull,
  output logic                          wr_ok,
  output logic                          tx_over,
  output logic                          rd_single,
  output logic                          rd_empty,
  output logic                          push_ok,
  output logic                          push_ovf
);
  localparam int BUF_W  = NBYTES * BYTE_W;
  localparam int HOST_W = HOST_BYTES * BYTE_W;
  localparam int CNT_W  = $clog2(NBYTES + 1);
  localparam int LIMIT  = NBYTES - HOST_BYTES;

  logic [BUF_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic             word_ok, byte_ok, st_en;

  assign word_ok = wr_word_en && (tx_q <= CNT_W'(LIMIT));
  assign byte_ok = wr_byte_en && (tx_q <= CNT_W'(LIMIT));
  assign st_en   = wr_word_en | wr_byte_en | rd_en | tx_pop | rx_push;

  always_comb begin
    buf_d     = buf_q;
    tx_d      = tx_q;
    rx_d      = rx_q;
    rd_single = 1'b0;
    rd_empty  = 1'b0;
    push_ok   = 1'b0;
    push_ovf  = 1'b0;
    if (word_ok) begin
      buf_d = {buf_q[BUF_W-HOST_W-1:0], wr_word};
      tx_d  = tx_q + CNT_W'(HOST_BYTES);
    end else if (byte_ok) begin
      buf_d = {buf_q[BUF_W-BYTE_W-1:0], wr_byte};
      tx_d  = tx_q + CNT_W'(1);
    end else if (rd_en) begin
      if ((rx_q != '0) && (rx_q < CNT_W'(HOST_BYTES))) begin
        rd_single = 1'b1;
        rx_d      = '0;
      end else if (rx_q >= CNT_W'(HOST_BYTES)) begin
        if (rx_q > CNT_W'(HOST_BYTES)) begin
          buf_d = buf_q >> HOST_W;
        end
        rx_d = rx_q - CNT_W'(HOST_BYTES);
      end
      rd_empty = (rx_d == '0);
    end else begin
      if (tx_pop && (tx_q != '0)) begin
        tx_d = tx_q - CNT_W'(1);
      end
      if (rx_push) begin
        if (rx_q < CNT_W'(NBYTES)) begin
          for (int i = 0; i < NBYTES; i++) begin
            if (rx_q == CNT_W'(i)) begin
              buf_d[i*BYTE_W +: BYTE_W] = rx_byte;
            end
          end
          rx_d    = rx_q + CNT_W'(1);
          push_ok = 1'b1;
        end else begin
          push_ovf = 1'b1;
        end
      end
    end
  end

  always_comb begin
    tx_head = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (tx_q == CNT_W'(i + 1)) begin
        tx_head = buf_q[i*BYTE_W +: BYTE_W];
      end
    end
  end

  assign head_word   = buf_q[HOST_W-1:0];
  assign tx_nonempty = (tx_q != '0);
  assign rx_notfull  = (rx_q < CNT_W'(NBYTES));
  assign wr_ok       = word_ok | byte_ok;
  assign tx_over     = (tx_d > CNT_W'(LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (st_en) begin
      buf_q <= buf_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  AST_TX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_q <= CNT_W'(NBYTES)); // R1
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_word_en && tx_q > CNT_W'(LIMIT)) |=> ($stable(tx_q) && $stable(buf_q))); // R1
  AST_RX_TWO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_q >= CNT_W'(HOST_BYTES)) |=> (rx_q == $past(rx_q) - CNT_W'(HOST_BYTES))); // R6
  AST_PUSH_FULL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && !rd_en && !wr_word_en && !wr_byte_en && rx_q == CNT_W'(NBYTES)) |=> $stable(rx_q)); // R8
endmodule

// File: rtl/hbp_flags.sv
module hbp_flags
  import hbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic              tx_over,
  input  logic              rd_en,
  input  logic              rd_single,
  input  logic              rd_empty,
  input  logic              push_ok,
  input  logic              push_ovf,
  input  logic              xrdy_set,
  input  logic              xudf_set,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] stat
);
  logic rrdy_q, xrdy_q, xudf_q, rovr_q, sbd_q;
  logic rrdy_d, xrdy_d, xudf_d, rovr_d, sbd_d;
  logic unused_clr;

  assign unused_clr = ^clr;

  always_comb begin
    rrdy_d = (rrdy_q & ~clr[FLG_RRDY] & ~rd_empty) | push_ok;
    xrdy_d = (xrdy_q & ~clr[FLG_XRDY] & ~(wr_ok & tx_over)) | xrdy_set;
    xudf_d = (xudf_q & ~clr[FLG_XUDF] & ~wr_ok) | xudf_set;
    rovr_d = (rovr_q & ~clr[FLG_ROVR] & ~rd_en) | push_ovf;
    sbd_d  = (sbd_q & ~clr[FLG_SBD]) | rd_single;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rrdy_q <= 1'b0;
      xrdy_q <= 1'b0;
      xudf_q <= 1'b0;
      rovr_q <= 1'b0;
      sbd_q  <= 1'b0;
    end else begin
      rrdy_q <= rrdy_d;
      xrdy_q <= xrdy_d;
      xudf_q <= xudf_d;
      rovr_q <= rovr_d;
      sbd_q  <= sbd_d;
    end
  end

  always_comb begin
    stat           = '0;
    stat[FLG_RRDY] = rrdy_q;
    stat[FLG_XRDY] = xrdy_q;
    stat[FLG_XUDF] = xudf_q;
    stat[FLG_ROVR] = rovr_q;
    stat[FLG_SBD]  = sbd_q;
  end

  AST_SBD_ON_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_single |=> stat[FLG_SBD]); // R6
  AST_ROVR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !push_ovf) |=> !stat[FLG_ROVR]); // R8
  AST_XUDF_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !xudf_set) |=> !stat[FLG_XUDF]); // R4
  AST_RRDY_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_empty && !push_ok) |=> !stat[FLG_RRDY]); // R7
endmodule

// File: rtl/bytepack_data_port.sv
module bytepack_data_port
  import hbp_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          host_wr16,
  input  logic                          host_wr8,
  input  logic                          host_rd,
  input  logic [HOST_BYTES*BYTE_W-1:0]  host_wdata,
  output logic [HOST_BYTES*BYTE_W-1:0]  host_rdata,
  input  logic                          swap_order,
  input  logic                          master_on,
  input  logic                          xmit_dir,
  input  logic [STAT_W-1:0]             flag_clr,
  output logic [STAT_W-1:0]             status,
  output logic                          eng_tx_avail,
  output logic [BYTE_W-1:0]             eng_tx_byte,
  input  logic                          eng_tx_pop,
  output logic                          eng_rx_space,
  input  logic                          eng_rx_push,
  input  logic [BYTE_W-1:0]             eng_rx_byte,
  input  logic                          eng_xrdy_set,
  input  logic                          eng_xudf_set,
  output logic                          kick,
  output logic                          rx_finish
);
  localparam int HOST_W = HOST_BYTES * BYTE_W;

  logic              host_any, eng_ok;
  logic [HOST_W-1:0] wr_image, head_word;
  logic              tx_nonempty, rx_notfull;
  logic              wr_ok, tx_over, rd_single, rd_empty, push_ok, push_ovf;
  logic              kick_d, fin_d;

  assign host_any = host_wr16 | host_wr8 | host_rd;
  assign eng_ok   = ~host_any;

  hbp_lane_swap #(.BYTE_W(BYTE_W), .LANES(HOST_BYTES)) u_wr_swap (
    .en   (~swap_order),
    .din  (host_wdata),
    .dout (wr_image)
  );

  hbp_lane_swap #(.BYTE_W(BYTE_W), .LANES(HOST_BYTES)) u_rd_swap (
    .en   (swap_order),
    .din  (head_word),
    .dout (host_rdata)
  );

  hbp_buffer #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_word_en  (host_wr16),
    .wr_byte_en  (host_wr8),
    .wr_word     (wr_image),
    .wr_byte     (host_wdata[BYTE_W-1:0]),
    .rd_en       (host_rd),
    .tx_pop      (eng_tx_pop & eng_ok),
    .rx_push     (eng_rx_push & eng_ok),
    .rx_byte     (eng_rx_byte),
    .head_word   (head_word),
    .tx_head     (eng_tx_byte),
    .tx_nonempty (tx_nonempty),
    .rx_notfull  (rx_notfull),
    .wr_ok       (wr_ok),
    .tx_over     (tx_over),
    .rd_single   (rd_single),
    .rd_empty    (rd_empty),
    .push_ok     (push_ok),
    .push_ovf    (push_ovf)
  );

  hbp_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .tx_over   (tx_over),
    .rd_en     (host_rd),
    .rd_single (rd_single),
    .rd_empty  (rd_empty),
    .push_ok   (push_ok),
    .push_ovf  (push_ovf),
    .xrdy_set  (eng_xrdy_set & eng_ok),
    .xudf_set  (eng_xudf_set & eng_ok),
    .clr       (flag_clr),
    .stat      (status)
  );

  assign eng_tx_avail = tx_nonempty & eng_ok;
  assign eng_rx_space = rx_notfull & eng_ok;

  assign kick_d = host_any;
  assign fin_d  = rd_empty & master_on & ~xmit_dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick      <= 1'b0;
      rx_finish <= 1'b0;
    end else begin
      kick      <= kick_d;
      rx_finish <= fin_d;
    end
  end

  AST_KICK_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    host_any |=> kick); // R9
  AST_KICK_ONLY_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !host_any |=> !kick); // R9
  AST_ONE_HOST_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({host_wr16, host_wr8, host_rd})); // R10
  AST_FINISH_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rx_finish |-> $past(host_rd)); // R7
endmodule

// File: tb/bytepack_data_port_tb_top.sv
module bytepack_data_port_tb_top;
  logic        clk, rst_n;
  logic        host_wr16, host_wr8, host_rd;
  logic [15:0] host_wdata, host_rdata;
  logic        swap_order, master_on, xmit_dir;
  logic [15:0] flag_clr, status;
  logic        eng_tx_avail, eng_tx_pop, eng_rx_space, eng_rx_push;
  logic [7:0]  eng_tx_byte, eng_rx_byte;
  logic        eng_xrdy_set, eng_xudf_set, kick, rx_finish;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  logic [7:0] txq [4];
  logic [7:0] rxq [4];
  int  txn, rxn;
  bit  m_rrdy, m_xrdy, m_xudf, m_rovr, m_sbd, m_kick, m_fin;

  bytepack_data_port dut_i (
    .clk(clk), .rst_n(rst_n),
    .host_wr16(host_wr16), .host_wr8(host_wr8), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .swap_order(swap_order), .master_on(master_on), .xmit_dir(xmit_dir),
    .flag_clr(flag_clr), .status(status),
    .eng_tx_avail(eng_tx_avail), .eng_tx_byte(eng_tx_byte), .eng_tx_pop(eng_tx_pop),
    .eng_rx_space(eng_rx_space), .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
    .eng_xrdy_set(eng_xrdy_set), .eng_xudf_set(eng_xudf_set),
    .kick(kick), .rx_finish(rx_finish)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat();
    logic [15:0] s;
    s = '0;
    s[3] = m_rrdy; s[4] = m_xrdy; s[10] = m_xudf; s[11] = m_rovr; s[15] = m_sbd;
    return s;
  endfunction

  task automatic check_reg();
    logic [15:0] e;
    e = exp_stat();
    chk("R7 rx ready bit3", status[3], e[3]);
    chk("R4 tx ready bit4", status[4], e[4]);
    chk("R4 underflow bit10", status[10], e[10]);
    chk("R8 overrun bit11", status[11], e[11]);
    chk("R6 single byte bit15", status[15], e[15]);
    chk("R9 kick", kick, m_kick);
    chk("R7 rx_finish", rx_finish, m_fin);
  endtask

  // One cycle: entered and left at a falling edge.
  task automatic cycle(input bit w16, input bit w8, input bit rd, input logic [15:0] wd,
                       input bit sw, input bit pop, input bit push, input logic [7:0] pb,
                       input bit xs, input bit us, input logic [15:0] clr,
                       input bit mo, input bit xd);
    bit host;
    check_reg();
    host_wr16 = w16; host_wr8 = w8; host_rd = rd; host_wdata = wd;
    swap_order = sw; eng_tx_pop = pop; eng_rx_push = push; eng_rx_byte = pb;
    eng_xrdy_set = xs; eng_xudf_set = us; flag_clr = clr;
    master_on = mo; xmit_dir = xd;
    #1;
    host = w16 | w8 | rd;
    chk("R10 tx_avail", eng_tx_avail, (txn > 0) && !host);
    chk("R10 rx_space", eng_rx_space, (rxn < 4) && !host);
    if (txn > 0) chk("R2 tx head byte", eng_tx_byte, txq[0]);
    if (rd && rxn >= 2)
      chk("R5 read word", host_rdata, sw ? {rxq[0], rxq[1]} : {rxq[1], rxq[0]});
    else if (rd && rxn == 1)
      chk("R5 read single", sw ? host_rdata[15:8] : host_rdata[7:0], rxq[0]);
    // model update
    if (clr[3])  m_rrdy = 0;
    if (clr[4])  m_xrdy = 0;
    if (clr[10]) m_xudf = 0;
    if (clr[11]) m_rovr = 0;
    if (clr[15]) m_sbd  = 0;
    m_kick = host;
    m_fin  = 0;
    if (w16) begin
      if (txn <= 2) begin
        txq[txn]   = sw ? wd[15:8] : wd[7:0];
        txq[txn+1] = sw ? wd[7:0]  : wd[15:8];
        txn += 2;
        m_xudf = 0;
        if (txn > 2) m_xrdy = 0;
      end
    end else if (w8) begin
      if (txn <= 2) begin
        txq[txn] = wd[7:0];
        txn += 1;
        m_xudf = 0;
        if (txn > 2) m_xrdy = 0;
      end
    end else if (rd) begin
      m_rovr = 0;
      if (rxn == 1) begin
        m_sbd = 1; rxn = 0;
      end else if (rxn >= 2) begin
        rxq[0] = rxq[2]; rxq[1] = rxq[3]; rxn -= 2;
      end
      if (rxn == 0) begin
        m_rrdy = 0;
        m_fin  = mo && !xd;
      end
    end else begin
      if (pop && txn > 0) begin
        for (int i = 0; i < 3; i++) txq[i] = txq[i+1];
        txn -= 1;
      end
      if (push) begin
        if (rxn < 4) begin
          rxq[rxn] = pb; rxn += 1; m_rrdy = 1;
        end else m_rovr = 1;
      end
      if (xs) m_xrdy = 1;
      if (us) m_xudf = 1;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(0,0,0,16'h0,0,0,0,8'h0,0,0,16'h0,0,0);
  endtask

  task automatic tx_head_is(input string tag, input logic [7:0] v);
    chk(tag, eng_tx_byte, v);
  endtask

  initial begin
    int phase;
    void'($urandom(32'd2024));
    rst_n = 0;
    host_wr16 = 0; host_wr8 = 0; host_rd = 0; host_wdata = 0; swap_order = 0;
    master_on = 0; xmit_dir = 0; flag_clr = 0; eng_tx_pop = 0; eng_rx_push = 0;
    eng_rx_byte = 0; eng_xrdy_set = 0; eng_xudf_set = 0;
    txn = 0; rxn = 0;
    m_rrdy = 0; m_xrdy = 0; m_xudf = 0; m_rovr = 0; m_sbd = 0; m_kick = 0; m_fin = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    chk("R10 reset status", status, 16'h0);
    chk("R9 reset kick", kick, 1'b0);
    chk("R10 reset tx_avail", eng_tx_avail, 1'b0);
    chk("R10 reset rx_space", eng_rx_space, 1'b1);
    @(negedge clk);

    // R1 / R2: two half-words with both orders, then a rejected one
    cycle(0,0,0,16'h0,0,0,0,8'h0,1,1,16'h0,0,1);       // set xrdy and xudf
    cycle(1,0,0,16'h1234,0,0,0,8'h0,0,0,16'h0,0,1);
    cycle(1,0,0,16'hABCD,1,0,0,8'h0,0,0,16'h0,0,1);
    cycle(1,0,0,16'h5555,0,0,0,8'h0,0,0,16'h0,0,1);    // rejected
    #1 tx_head_is("R1 head after reject", 8'h34);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    #1 tx_head_is("R2 low byte first", 8'h12);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    #1 tx_head_is("R2 high byte first", 8'hAB);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    #1 chk("R1 drained after reject", eng_tx_avail, 1'b0);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);       // pop on empty ignored

    // R3: half-word, byte, rejected byte
    cycle(1,0,0,16'h2211,0,0,0,8'h0,0,0,16'h0,0,1);
    cycle(0,1,0,16'h0077,0,0,0,8'h0,0,0,16'h0,0,1);
    cycle(0,1,0,16'h0088,0,0,0,8'h0,0,0,16'h0,0,1);    // rejected
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    #1 tx_head_is("R3 byte write is last", 8'h77);
    cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,1);
    #1 chk("R3 second byte rejected", eng_tx_avail, 1'b0);

    // R6 / R8: three pushes, reads, overflow
    cycle(0,0,0,16'h0,0,0,1,8'hA1,0,0,16'h0,1,0);
    cycle(0,0,0,16'h0,0,0,1,8'hB2,0,0,16'h0,1,0);
    cycle(0,0,0,16'h0,0,0,1,8'hC3,0,0,16'h0,1,0);
    cycle(0,0,1,16'h0,0,0,0,8'h0,0,0,16'h0,1,0);
    cycle(0,0,1,16'h0,1,0,0,8'h0,0,0,16'h0,1,0);       // single byte, finishes
    for (int i = 0; i < 5; i++) cycle(0,0,0,16'h0,0,0,1,8'(i+8'h40),0,0,16'h0,1,0);
    cycle(0,0,0,16'h0,0,0,0,8'h0,0,0,16'h8808,1,0);
    cycle(0,0,1,16'h0,0,0,0,8'h0,0,0,16'h0,1,0);
    cycle(0,0,1,16'h0,1,0,0,8'h0,0,0,16'h0,1,0);
    idle();

    // Random phases
    phase = 0;
    for (int blk = 0; blk < 60; blk++) begin
      for (int k = 0; k < 50; k++) begin
        int op;
        logic [15:0] clr;
        op  = $urandom_range(0, 5);
        clr = ($urandom_range(0, 7) == 0) ? 16'($urandom) : 16'h0;
        if (phase == 0)
          cycle(op == 0 || op == 1, op == 2, op == 3, 16'($urandom), 1'($urandom),
                1'($urandom), 0, 8'h0, 1'($urandom_range(0,3)==0),
                1'($urandom_range(0,3)==0), clr, 1'($urandom), 1'($urandom));
        else
          cycle(0, 0, op <= 1, 16'h0, 1'($urandom), 1'($urandom),
                op >= 2, 8'($urandom), 1'($urandom_range(0,3)==0),
                1'($urandom_range(0,3)==0), clr, 1'($urandom), 1'($urandom));
      end
      while (txn > 0) cycle(0,0,0,16'h0,0,1,0,8'h0,0,0,16'h0,0,0);
      while (rxn > 0) cycle(0,0,1,16'h0,1'($urandom),0,0,8'h0,0,0,16'h0,1,0);
      phase = 1 - phase;
    end
    idle();
    check_reg();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule